// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter with Break

This block sends characters on a single serial line, one bit at a time, in the familiar asynchronous format. A character written over the bus goes into a holding register. On the next bit-rate boundary at which the line is free, the character moves into a separate shift register. The holding register is then free for the next character, so characters can follow one another with no idle gap. A programmable divider sets the bit rate from the system clock. Each bit lasts `baud_div + 1` clock cycles.

Enabling the transmitter queues one idle preamble, which is a character-long stretch of high line. Holding the break control sends continuous all-zero frames. Once break is released, at least one high bit follows. When the transmitter is disabled, the character already in the shift register is sent to the end before the line rests high.

Two status flags are kept apart:
- the holding-register-empty flag;
- the transmission-complete flag.

Either flag can raise the interrupt request, each through its own enable. Both flags clear only through a status read followed by a data write.

The write port is valid/ready. `wr_ready` is high exactly when the holding register is empty, and a write completes on a clock edge where both `wr_valid` and `wr_ready` are high. While the holding register is full, `wr_ready` stays low and `wr_data` is not sampled. A character that is already held is never overwritten.

Top module: `sci_tx_dbuf`

## Requirements
- R1: After reset, `txd` is 1, `tdre` is 1, `tc` is 1 and `wr_ready` is 1, and `irq` equals `(tdre & ie_empty) | (tc & ie_done)` from that point onward.
- R2: A write is accepted only while `wr_ready` is 1. Once a character is accepted, `wr_ready` is 0 until that character moves into the shift register, and the held character is never lost or changed.
- R3: A held character moves into the shift register only on a bit-rate tick while `tx_en` is 1. That move sets `tdre` on the same edge on which the start bit appears on `txd`.
- R4: A data frame has the following layout:
  - one start bit (0);
  - the data, least significant bit first (8 bits, or 9 bits when `len9` is 1, with the ninth bit taken from `bit8`);
  - one stop bit (1).
  Each bit lasts exactly `baud_div + 1` cycles.
- R5: `tc` sets when a frame ends and nothing is pending (no data, preamble or break).
- R6: When `tx_en` falls in the middle of a frame, that frame is sent whole, the line then stays at 1, and `tc` sets. A character written while disabled waits until `tx_en` returns.
- R7: A rising edge of `tx_en` queues one preamble: an all-ones stretch lasting one full character (10 bit times in 8-bit mode, 11 in 9-bit mode), sent before any other frame.
- R8: While `brk_req` and `tx_en` are both 1, all-zero frames are sent back to back. After `brk_req` clears, the line is high for at least one bit time before any following start bit.
- R9: A `stat_rd` pulse followed by an accepted write clears both `tdre` and `tc`. An accepted write with no status read since the previous write leaves both flags unchanged.
- R10: When several kinds of frame are pending, they are sent in this order: preamble first, then break, then held data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request for the holding register |
| wr_ready | output | 1 | Holding register empty; a write is accepted when both are high |
| wr_data | input | DW (8) | Character to send |
| stat_rd | input | 1 | Status-read strobe; arms the flag-clear sequence |
| tx_en | input | 1 | Transmitter enable |
| brk_req | input | 1 | Send break frames while high |
| len9 | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| bit8 | input | 1 | Ninth data bit, used in 9-bit mode |
| ie_empty | input | 1 | Interrupt enable for `tdre` |
| ie_done | input | 1 | Interrupt enable for `tc` |
| baud_div | input | DIV_W (12) | Bit time minus one, in clock cycles |
| txd | output | 1 | Serial line, idles high |
| tdre | output | 1 | Holding-register-empty flag |
| tc | output | 1 | Transmission-complete flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses four kinds of input pattern:
- **Random bursts.** Random characters are written as fast as back-pressure allows, with random word length, ninth bit and divider. These bursts separate correct framing and bit order from off-by-one bit widths, and from lost or duplicated characters under back-pressure.
- **Single write after enable.** A single `0x01` written just after the transmitter is enabled exposes the preamble length, the tick-aligned load that sets `tdre`, and the exact start-bit width.
- **Disable part-way and write while disabled.** Disabling in the middle of a character, then writing while disabled, shows the difference between finishing and truncating a character, and between holding and dropping pending data.
- **Break with held data, and unarmed write.** Holding break with data already queued checks the ordering of preamble, break and data, and the stop bit that follows a break. A write made without a prior status read checks that the flag clear needs both steps.

// File: rtl/sci_tx_pkg.sv
package sci_tx_pkg;

  // Kind of frame offered to the shift register.
  typedef enum logic [1:0] {
    FK_NONE = 2'd0,
    FK_DATA = 2'd1,
    FK_PRE  = 2'd2,
    FK_BRK  = 2'd3
  } frame_kind_e;

endpackage

// File: rtl/sci_tx_bitclk.sv
module sci_tx_bitclk #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  assign tick = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= div;
    else           cnt_q <= cnt_q - DIV_W'(1);
  end

  // R4: with a divider above zero, two ticks are never adjacent
  a_r4_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0 && $stable(div)) |=> !tick);

endmodule

// File: rtl/sci_tx_shifter.sv
module sci_tx_shifter
  import sci_tx_pkg::*;
#(
  parameter int FW = 11,
  parameter int LW = $clog2(FW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          req,
  input  frame_kind_e   req_kind,
  input  logic [FW-1:0] req_frame,
  input  logic [LW-1:0] req_len,
  output logic          take,
  output logic          done,
  output logic          busy,
  output logic          txd
);

  logic [FW-1:0] sh_q;
  logic [LW-1:0] rem_q;      // bits still on the line, current one included
  logic          txd_q;
  logic          brk_last_q; // last frame sent was a break
  logic          last_bit;
  logic          tail_need;
  logic          at_end;

  always_comb begin
    last_bit  = (rem_q == LW'(1));
    at_end    = tick && (last_bit || rem_q == '0);
    tail_need = brk_last_q && last_bit && !(req && req_kind == FK_BRK);
    take      = at_end && req && !tail_need;
    done      = tick && last_bit && !take && !tail_need;
  end

  assign busy = (rem_q != '0);
  assign txd  = txd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q       <= '0;
      rem_q      <= '0;
      txd_q      <= 1'b1;
      brk_last_q <= 1'b0;
    end else if (take) begin
      txd_q      <= req_frame[0];
      sh_q       <= req_frame >> 1;
      rem_q      <= req_len;
      brk_last_q <= (req_kind == FK_BRK);
    end else if (tick && tail_need) begin
      txd_q      <= 1'b1;          // one stop bit after a break
      rem_q      <= LW'(1);
      brk_last_q <= 1'b0;
    end else if (tick && rem_q > LW'(1)) begin
      txd_q <= sh_q[0];
      sh_q  <= sh_q >> 1;
      rem_q <= rem_q - LW'(1);
    end else if (tick && last_bit) begin
      txd_q <= 1'b1;
      rem_q <= '0;
    end
  end

  // R4: the line only changes on a bit boundary
  a_r4_line_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(txd_q));

  // R6: an idle shifter leaves the line high
  a_r6_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_q == '0) |-> txd_q);

  // R8: a break that is not continued is followed by a high bit
  a_r8_break_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_last_q && tick && last_bit && !(req && req_kind == FK_BRK)) |=> txd_q);

endmodule

// File: rtl/sci_tx_ctl.sv
module sci_tx_ctl
  import sci_tx_pkg::*;
#(
  parameter int DW = 8,
  parameter int FW = DW + 3,
  parameter int LW = $clog2(FW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  input  logic          stat_rd,
  input  logic          tx_en,
  input  logic          brk_req,
  input  logic          len9,
  input  logic          bit8,
  input  logic          take,
  input  logic          done,
  input  logic          busy,
  output logic          req,
  output frame_kind_e   kind,
  output logic [FW-1:0] frame,
  output logic [LW-1:0] flen,
  output logic          tdre,
  output logic          tc
);

  logic [DW-1:0] hold_q;
  logic          hold_full_q;
  logic          en_q;
  logic          pend_pre_q;
  logic          armed_q;
  logic          tdre_q;
  logic          tc_q;
  logic          wr_fire;
  logic          en_rise;
  logic          move_data;
  logic          move_pre;

  always_comb begin
    en_rise  = tx_en && !en_q;
    wr_ready = !hold_full_q;
    wr_fire  = wr_valid && wr_ready;
    // R10: preamble, then break, then held data
    if (!tx_en)                       kind = FK_NONE;
    else if (pend_pre_q || en_rise)   kind = FK_PRE;
    else if (brk_req)                 kind = FK_BRK;
    else if (hold_full_q)             kind = FK_DATA;
    else                              kind = FK_NONE;
    req       = (kind != FK_NONE);
    move_data = take && (kind == FK_DATA);
    move_pre  = take && (kind == FK_PRE);
  end

  // Frame image, sent from bit 0 upward
  always_comb begin
    case (kind)
      FK_BRK:  frame = '0;
      FK_DATA: frame = len9 ? {1'b1, bit8, hold_q, 1'b0}
                            : {1'b0, 1'b1, hold_q, 1'b0};
      default: frame = '1;
    endcase
    flen = len9 ? LW'(DW + 3) : LW'(DW + 2);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      en_q        <= 1'b0;
      pend_pre_q  <= 1'b0;
      armed_q     <= 1'b0;
      tdre_q      <= 1'b1;
      tc_q        <= 1'b1;
    end else begin
      en_q <= tx_en;

      if (!tx_en)        pend_pre_q <= 1'b0;
      else if (move_pre) pend_pre_q <= 1'b0;
      else if (en_rise)  pend_pre_q <= 1'b1;

      if (move_data) hold_full_q <= 1'b0;
      else if (wr_fire) begin
        hold_full_q <= 1'b1;
        hold_q      <= wr_data;
      end

      if (wr_fire)      armed_q <= 1'b0;
      else if (stat_rd) armed_q <= 1'b1;

      if (move_data)               tdre_q <= 1'b1;
      else if (wr_fire && armed_q) tdre_q <= 1'b0;

      if (done || (!tx_en && !busy)) tc_q <= 1'b1;
      else if (wr_fire && armed_q)   tc_q <= 1'b0;
    end
  end

  assign tdre = tdre_q;
  assign tc   = tc_q;

  // R3: moving a character into the shift register raises the empty flag
  a_r3_tdre_on_move: assert property (@(posedge clk) disable iff (!rst_n)
    move_data |=> tdre_q);

  // R2: a held character stays put until it is moved
  a_r2_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full_q && !move_data) |=> (hold_full_q && $stable(hold_q)));

  // R6: a stopped, idle transmitter reports completion
  a_r6_tc_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !busy) |=> tc_q);

endmodule

// File: rtl/sci_tx_dbuf.sv
module sci_tx_dbuf
  import sci_tx_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [DW-1:0]    wr_data,
  input  logic             stat_rd,
  input  logic             tx_en,
  input  logic             brk_req,
  input  logic             len9,
  input  logic             bit8,
  input  logic             ie_empty,
  input  logic             ie_done,
  input  logic [DIV_W-1:0] baud_div,
  output logic             txd,
  output logic             tdre,
  output logic             tc,
  output logic             irq
);

  localparam int FW = DW + 3;
  localparam int LW = $clog2(FW + 1);

  logic          tick;
  logic          req;
  frame_kind_e   kind;
  logic [FW-1:0] frame;
  logic [LW-1:0] flen;
  logic          take;
  logic          done;
  logic          busy;

  sci_tx_bitclk #(.DIV_W(DIV_W)) u_bitclk (
    .clk  (clk),
    .rst_n(rst_n),
    .div  (baud_div),
    .tick (tick)
  );

  sci_tx_ctl #(.DW(DW), .FW(FW), .LW(LW)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_valid(wr_valid),
    .wr_data (wr_data),
    .wr_ready(wr_ready),
    .stat_rd (stat_rd),
    .tx_en   (tx_en),
    .brk_req (brk_req),
    .len9    (len9),
    .bit8    (bit8),
    .take    (take),
    .done    (done),
    .busy    (busy),
    .req     (req),
    .kind    (kind),
    .frame   (frame),
    .flen    (flen),
    .tdre    (tdre),
    .tc      (tc)
  );

  sci_tx_shifter #(.FW(FW), .LW(LW)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .req      (req),
    .req_kind (kind),
    .req_frame(frame),
    .req_len  (flen),
    .take     (take),
    .done     (done),
    .busy     (busy),
    .txd      (txd)
  );

  assign irq = (tdre && ie_empty) || (tc && ie_done);

endmodule

// File: tb/sim_sci_tx_dbuf.sv
module sim_sci_tx_dbuf;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, wr_ready;
  logic [7:0] wr_data = '0;
  logic stat_rd = 0, tx_en = 0, brk_req = 0, len9 = 0, bit8 = 0;
  logic ie_empty = 0, ie_done = 0;
  logic [11:0] baud_div = 12'd3;
  logic txd, tdre, tc, irq;

  int n_chk = 0, n_fail = 0;
  longint cyc = 0;
  bit finished = 0;

  sci_tx_dbuf u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_char(input logic [7:0] d, input bit nine, input bit b8);
    return nine ? {b8, d} : {1'b0, d};
  endfunction

  task automatic wr(input logic [7:0] d);
    do @(negedge clk); while (!wr_ready);
    wr_valid = 1; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic rd_status();
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
  endtask

  task automatic rx_frame(input int p, input bit nine, input bit fell,
                          output logic [8:0] v, output bit ok);
    int guard = 0;
    v = '0; ok = 1;
    if (!fell) begin
      do begin @(negedge clk); guard++; end while (txd !== 1'b0 && guard < 20000);
      if (guard >= 20000) ok = 0;
    end
    repeat ((p - 1) / 2) @(negedge clk);
    if (txd !== 1'b0) ok = 0;
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      repeat (p) @(negedge clk);
      v[i] = txd;
    end
    repeat (p) @(negedge clk);
    if (txd !== 1'b1) ok = 0;
  endtask

  task automatic wait_tc();
    int guard = 0;
    while (tc !== 1'b1 && guard < 20000) begin @(negedge clk); guard++; end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [8:0] v;
    bit ok;
    int p, cnt;
    longint t0;
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(txd === 1'b1, "R1 txd", txd, 1);
    check(tdre === 1'b1, "R1 tdre", tdre, 1);
    check(tc === 1'b1, "R1 tc", tc, 1);
    check(wr_ready === 1'b1, "R1 wr_ready", wr_ready, 1);
    check(irq === 1'b0, "R1 irq masked", irq, 0);
    ie_empty = 1; #1;
    check(irq === 1'b1, "R1 irq from tdre", irq, 1);
    ie_empty = 0;

    // R7/R3/R4/R9: enable, armed write of 0x01
    p = 4; baud_div = 12'(p - 1);
    @(negedge clk); tx_en = 1; t0 = cyc;
    rd_status();
    wr(8'h01);
    check(tdre === 1'b0, "R9 tdre cleared", tdre, 0);
    check(tc === 1'b0, "R9 tc cleared", tc, 0);
    while (txd === 1'b1 && cyc - t0 < 1000) @(negedge clk);
    check((cyc - t0) >= 10*p && (cyc - t0) <= 11*p + 2, "R7 preamble length", cyc - t0, 10*p);
    check(tdre === 1'b1, "R3 tdre with start bit", tdre, 1);
    cnt = 0;
    while (txd === 1'b0 && cnt < 100) begin cnt++; @(negedge clk); end
    check(cnt == p, "R4 start bit width", cnt, p);
    ie_done = 1;
    wait_tc();
    check(tc === 1'b1 && txd === 1'b1, "R5 tc after frame", {tc, txd}, 2'b11);
    check(irq === 1'b1, "R5 irq from tc", irq, 1);
    ie_done = 0; #1;
    check(irq === 1'b0, "R5 irq masked", irq, 0);

    // R4/R2: random bursts
    for (int b = 0; b < 4; b++) begin
      logic [8:0] expq[6];
      bit nine, b8;
      wait_tc();
      p = 2 + int'($urandom_range(0, 4));
      nine = 1'($urandom_range(0, 1));
      b8 = 1'($urandom_range(0, 1));
      @(negedge clk);
      baud_div = 12'(p - 1); len9 = nine; bit8 = b8;
      fork
        begin
          for (int i = 0; i < 6; i++) begin
            logic [7:0] d;
            d = 8'($urandom_range(0, 255));
            expq[i] = exp_char(d, nine, b8);
            rd_status();
            wr(d);
            check(wr_ready === 1'b0, "R2 back-pressure after write", wr_ready, 0);
          end
        end
        begin
          for (int i = 0; i < 6; i++) begin
            logic [8:0] rv;
            bit rok;
            rx_frame(p, nine, 0, rv, rok);
            check(rok, "R4 frame start/stop", rok, 1);
            check(rv == expq[i], "R4 data bits", rv, expq[i]);
          end
        end
      join
      wait_tc();
      check(tc === 1'b1, "R5 tc after burst", tc, 1);
    end

    // R6: disable mid-frame, then write while disabled
    @(negedge clk); len9 = 0; p = 4; baud_div = 12'(p - 1);
    fork
      rx_frame(p, 0, 0, v, ok);
      begin
        do @(negedge clk); while (txd === 1'b1);
        repeat (3 * p) @(negedge clk);
        tx_en = 0;
      end
      wr(8'hA5);
    join
    check(ok && v == 9'h0A5, "R6 frame finished after disable", v, 9'h0A5);
    repeat (p + 2) @(negedge clk);
    check(txd === 1'b1 && tc === 1'b1, "R6 idle and tc after disable", {txd, tc}, 2'b11);
    wr(8'h3C);
    check(wr_ready === 1'b0, "R6 data held while disabled", wr_ready, 0);
    cnt = 0;
    repeat (40 * p) begin @(negedge clk); if (txd !== 1'b1) cnt++; end
    check(cnt == 0, "R6 line quiet while disabled", cnt, 0);
    tx_en = 1; t0 = cyc;
    while (txd === 1'b1 && cyc - t0 < 1000) @(negedge clk);
    check((cyc - t0) >= 10*p, "R7 preamble before held data", cyc - t0, 10*p);
    rx_frame(p, 0, 1, v, ok);
    check(ok && v == 9'h03C, "R6 held data sent on enable", v, 9'h03C);

    // R8/R10: break with data held
    wait_tc();
    @(negedge clk); tx_en = 0;
    wait_tc();
    wr(8'h5A);
    brk_req = 1;
    @(negedge clk); tx_en = 1; t0 = cyc;
    while (txd === 1'b1 && cyc - t0 < 1000) @(negedge clk);
    check((cyc - t0) >= 10*p, "R10 preamble before break", cyc - t0, 10*p);
    cnt = 0;
    repeat (25 * p) begin
      if (txd !== 1'b0 || wr_ready !== 1'b0) cnt++;
      @(negedge clk);
    end
    check(cnt == 0, "R8 continuous break, R10 data waits", cnt, 0);
    brk_req = 0;
    cnt = 0;
    while (txd === 1'b0 && cnt < 1000) begin @(negedge clk); cnt++; end
    cnt = 0;
    while (txd === 1'b1 && cnt < 1000) begin @(negedge clk); cnt++; end
    check(cnt >= p, "R8 stop bit after break", cnt, p);
    rx_frame(p, 0, 1, v, ok);
    check(ok && v == 9'h05A, "R10 data after break", v, 9'h05A);

    // R9: unarmed write leaves flags alone
    wait_tc();
    repeat (2) @(negedge clk);
    wr(8'h11);
    check(tdre === 1'b1, "R9 unarmed write keeps tdre", tdre, 1);
    check(tc === 1'b1, "R9 unarmed write keeps tc", tc, 1);
    wait_tc();

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule